// File: doc/BRIEF.md
# DMA Channel Group Interrupt and Register Decoder

This block is the shared front end for a group of DMA channels. It sits on a simple 32-bit register bus and splits the address space in two. A few global registers live in the block itself. The rest of the space is cut into one window per channel, which is steered to that channel through a one-hot select, a local offset and a read-data return path. Channels come in pairs: the even member of a pair moves data in (receive) and the odd member moves data out (transmit). Each pair occupies one 64-byte instance slot.

Each channel reports the end of a transfer with a single-cycle done pulse. The block latches these pulses into a status register that software clears by writing ones. An enable register masks the status. A read-only pending view shows the masked result, and one interrupt line is raised while any pending bit is set. Software can silence the line by writing zero to the enable register without losing any latched completion. A one-bit control register selects 32-bit addressing for the channels.

Reads return data combinationally for the address presented in the same cycle. Writes take effect at the next rising clock edge.

Top module: `dma_irq_decode`

## Requirements
- R1: After reset, the status, enable and addressing-control registers are zero and `irq` is low.
- R2: A high `done[n]` at a clock edge sets bit n of the status register, readable at address 0x080000.
- R3: A write to 0x080000 clears every status bit whose data bit is 1 and leaves bits written as 0 unchanged. Writing all ones clears every bit, and writing zero changes nothing.
- R4: If a clear and a done pulse hit the same status bit in the same cycle, the bit ends up set. A clear of a different bit in that cycle still takes effect.
- R5: The enable register at 0x080008 is read/write. The pending register at 0x080004 reads status AND enable, and writes to it change neither status nor enable.
- R6: `irq` is high exactly when pending is nonzero. Writing 0 to enable drops `irq` and keeps the status bits, and re-enabling a bit raises `irq` again.
- R7: Channel n has its base at (n/2)*0x40, plus 0x18 when n is odd. Within a 64-byte instance, local offsets 0x00–0x17 and 0x30–0x3F belong to the even channel and 0x18–0x2F belong to the odd channel. For a decoded access, `ch_sel` is one-hot on that channel, `ch_offs` is the byte offset from the channel base, and `bus_rdata` is that channel's slice of `ch_rdata`.
- R8: The addressing-control register is at 0x34. Bit 0 is read/write and drives `addr32_en`, and the other bits read zero. This address takes priority over the window of channel 0.
- R9: In status, enable and pending, the bits at positions NUM_CH and above read zero and cannot be set.
- R10: Reads of undecoded addresses return zero with `ch_sel` all zero. Writes to them change no register.
- R11: Address bits 1:0 are ignored, so every register is decoded on its 32-bit word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address |
| done | input | NUM_CH | Per-channel completion pulses |
| irq | output | 1 | Interrupt, high while pending is nonzero |
| addr32_en | output | 1 | 32-bit addressing select for the channels |
| ch_sel | output | NUM_CH | One-hot select of the addressed channel during an access |
| ch_offs | output | 6 | Byte offset within the selected channel's window |
| ch_rdata | input | 32*NUM_CH | Read data returned by each channel |

## Verification
The bench targets the cycle in which a clear write and a done pulse land on the same bit. A design that gives the clear priority would silently lose a completion. It checks that writing zeros to the status register leaves it untouched; a design that stores the written value instead would wipe every bit. It walks the instance layout through the transmit offset and the high region of a pair that belongs to the receive channel, so an off-by-0x18 or a wrong parity split shows up as the wrong channel data. It also checks that 0x34 lands on the control register rather than on channel 0. Finally it pushes all-ones into the enable register and into undecoded addresses: a design that keeps bits above the channel count, or that lets a stray write alias onto a real register, returns nonzero where zero is expected.

// File: rtl/dma_irq_decode.sv
module dma_irq_decode #(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 20
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  input  logic [NUM_CH-1:0]     done,
  output logic                  irq,
  output logic                  addr32_en,
  output logic [NUM_CH-1:0]     ch_sel,
  output logic [5:0]            ch_offs,
  input  logic [32*NUM_CH-1:0]  ch_rdata
);
  localparam int NUM_INST = (NUM_CH + 1) / 2;
  localparam int INST_W   = ADDR_W - 6;
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(32'h0008_0000);
  localparam logic [ADDR_W-1:0] PEND_A = ADDR_W'(32'h0008_0004);
  localparam logic [ADDR_W-1:0] ENAB_A = ADDR_W'(32'h0008_0008);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(32'h0000_0034);
  localparam logic [ADDR_W-1:0] WIN_END = ADDR_W'(NUM_INST * 64);

  logic [NUM_CH-1:0] status_q, enable_q, pending, ch_hit, clr_mask;
  logic              ctrl_q;
  logic [ADDR_W-1:0] addr_w;
  logic [INST_W-1:0] inst;
  logic [5:0]        loc;
  logic              hit_stat, hit_pend, hit_enab, hit_ctrl, in_win, odd_side;
  logic              unused_bits;

  assign addr_w   = bus_addr & ~ADDR_W'(3);
  assign inst     = addr_w[ADDR_W-1:6];
  assign loc      = addr_w[5:0];
  assign hit_stat = addr_w == STAT_A;
  assign hit_pend = addr_w == PEND_A;
  assign hit_enab = addr_w == ENAB_A;
  assign hit_ctrl = addr_w == CTRL_A;
  assign in_win   = (addr_w < WIN_END) && !hit_ctrl;
  assign odd_side = (loc >= 6'h18) && (loc < 6'h30);
  assign ch_offs  = odd_side ? loc - 6'h18 : loc;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign ch_hit[i] = in_win && (inst == INST_W'(i / 2)) && (odd_side == ((i % 2) == 1));
  end

  assign ch_sel  = ch_hit & {NUM_CH{bus_rd | bus_wr}};
  assign pending = status_q & enable_q;
  assign irq     = |pending;
  assign addr32_en = ctrl_q;
  assign clr_mask  = (bus_wr && hit_stat) ? bus_wdata[NUM_CH-1:0] : '0;
  assign unused_bits = ^{bus_wdata, bus_addr[1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      enable_q <= '0;
      ctrl_q   <= 1'b0;
    end else begin
      status_q <= (status_q & ~clr_mask) | done;
      if (bus_wr && hit_enab) enable_q <= bus_wdata[NUM_CH-1:0];
      if (bus_wr && hit_ctrl) ctrl_q <= bus_wdata[0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_stat) bus_rdata[NUM_CH-1:0] = status_q;
    if (hit_pend) bus_rdata[NUM_CH-1:0] = pending;
    if (hit_enab) bus_rdata[NUM_CH-1:0] = enable_q;
    if (hit_ctrl) bus_rdata[0] = ctrl_q;
    for (int i = 0; i < NUM_CH; i++)
      if (ch_hit[i]) bus_rdata = ch_rdata[i*32 +: 32];
  end
endmodule

// File: rtl/dma_irq_decode_chk.sv
module dma_irq_decode_chk #(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [NUM_CH-1:0] wr_bits,
  input logic [31:0]       bus_rdata,
  input logic [NUM_CH-1:0] done,
  input logic              irq,
  input logic [NUM_CH-1:0] ch_sel,
  input logic [NUM_CH-1:0] status_q,
  input logic [NUM_CH-1:0] enable_q
);
  logic [ADDR_W-1:0] aw;
  assign aw = bus_addr & ~ADDR_W'(3);

  a_r2_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(done)) == $past(done)));

  a_r3_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && aw == ADDR_W'(32'h80000) && done == '0) |=> ((status_q & $past(wr_bits)) == '0));

  a_r5_pending_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && aw == ADDR_W'(32'h80004) && done == '0) |=> ($stable(status_q) && $stable(enable_q)));

  a_r6_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status_q != '0 && enable_q != '0));

  a_r6_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_q == '0) |-> !irq);

  a_r7_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_sel));

  a_r10_undecoded_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (aw > ADDR_W'(32'h80008)) |-> (ch_sel == '0 && bus_rdata == '0));
endmodule

bind dma_irq_decode dma_irq_decode_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .wr_bits(bus_wdata[NUM_CH-1:0]), .bus_rdata(bus_rdata), .done(done),
  .irq(irq), .ch_sel(ch_sel), .status_q(status_q), .enable_q(enable_q)
);

// File: tb/dma_irq_decode_test.sv
`timescale 1ns/1ps
module dma_irq_decode_test;
  localparam int N  = 8;
  localparam int AW = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [N-1:0] done = '0;
  logic irq, addr32_en;
  logic [N-1:0] ch_sel;
  logic [5:0] ch_offs;
  logic [32*N-1:0] ch_rdata;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dma_irq_decode #(.NUM_CH(N), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .done(done), .irq(irq),
    .addr32_en(addr32_en), .ch_sel(ch_sel), .ch_offs(ch_offs), .ch_rdata(ch_rdata));

  initial for (int i = 0; i < N; i++) ch_rdata[i*32 +: 32] = 32'hC0DE_0000 + i;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = AW'(a); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = AW'(a); bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse(logic [N-1:0] m);
    @(negedge clk); done = m;
    @(negedge clk); done = '0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 irq", 32'(irq), 0);
    rd(32'h80000, d); check("R1 status", d, 0);
    rd(32'h80008, d); check("R1 enable", d, 0);
    rd(32'h34, d);    check("R1 ctrl", d, 0);
  endtask

  task automatic t_set_clear;
    logic [31:0] d;
    pulse(8'h05);
    rd(32'h80000, d); check("R2 status set", d, 32'h05);
    check("R2 irq masked", 32'(irq), 0);
    wr(32'h80000, 32'h4); rd(32'h80000, d); check("R3 clear one", d, 32'h01);
    wr(32'h80000, 32'h0); rd(32'h80000, d); check("R3 zero write", d, 32'h01);
    wr(32'h80000, 32'hFFFF_FFFF); rd(32'h80000, d); check("R3 clear all", d, 0);
  endtask

  task automatic t_set_wins;
    logic [31:0] d;
    pulse(8'h24);
    @(negedge clk);
    bus_addr = AW'(32'h80000); bus_wdata = 32'h24; bus_wr = 1'b1; done = 8'h04;
    @(negedge clk);
    bus_wr = 1'b0; done = '0;
    rd(32'h80000, d); check("R4 set wins", d, 32'h04);
    wr(32'h80000, 32'hFF);
  endtask

  task automatic t_enable_pending;
    logic [31:0] d;
    pulse(8'h12);
    wr(32'h80008, 32'h02);
    rd(32'h80004, d); check("R5 pending", d, 32'h02);
    check("R6 irq on", 32'(irq), 1);
    wr(32'h80004, 32'hFF);
    rd(32'h80004, d); check("R5 pending ro", d, 32'h02);
    rd(32'h80008, d); check("R5 enable kept", d, 32'h02);
    wr(32'h80008, 32'h0);
    check("R6 irq masked", 32'(irq), 0);
    rd(32'h80000, d); check("R6 status kept", d, 32'h12);
    wr(32'h80008, 32'h10);
    check("R6 irq again", 32'(irq), 1);
    wr(32'h80000, 32'hFF);
    check("R6 irq drops", 32'(irq), 0);
  endtask

  task automatic t_width;
    logic [31:0] d;
    wr(32'h80008, 32'hFFFF_FFFF);
    rd(32'h80008, d); check("R9 enable width", d, 32'hFF);
    pulse(8'hFF);
    rd(32'h80000, d); check("R9 status width", d, 32'hFF);
    rd(32'h80004, d); check("R9 pending width", d, 32'hFF);
    wr(32'h80000, 32'hFFFF_FFFF); wr(32'h80008, 0);
  endtask

  task automatic t_windows;
    logic [31:0] d;
    @(negedge clk); bus_addr = AW'(32'h58); bus_rd = 1'b1; #1;
    check("R7 ch3 data", bus_rdata, 32'hC0DE_0003);
    check("R7 ch3 sel", 32'(ch_sel), 32'h08);
    check("R7 ch3 offs", 32'(ch_offs), 0);
    @(negedge clk); bus_addr = AW'(32'h70); #1;
    check("R7 ch2 high data", bus_rdata, 32'hC0DE_0002);
    check("R7 ch2 high offs", 32'(ch_offs), 32'h30);
    @(negedge clk); bus_addr = AW'(32'hC4); #1;
    check("R7 ch6 data", bus_rdata, 32'hC0DE_0006);
    check("R7 ch6 offs", 32'(ch_offs), 4);
    @(negedge clk); bus_addr = AW'(32'hEC); #1;
    check("R7 ch7 data", bus_rdata, 32'hC0DE_0007);
    check("R7 ch7 offs", 32'(ch_offs), 32'h14);
    @(negedge clk); bus_rd = 1'b0; bus_addr = AW'(32'h18); bus_wr = 1'b1; #1;
    check("R7 write sel", 32'(ch_sel), 32'h02);
    @(negedge clk); bus_wr = 1'b0; #1;
    check("R7 idle sel", 32'(ch_sel), 0);
    rd(32'h5A, d); check("R11 low bits", d, 32'hC0DE_0003);
  endtask

  task automatic t_ctrl;
    logic [31:0] d;
    wr(32'h34, 32'hFFFF_FFFF);
    check("R8 addr32_en", 32'(addr32_en), 1);
    @(negedge clk); bus_addr = AW'(32'h34); bus_rd = 1'b1; #1;
    check("R8 read", bus_rdata, 1);
    check("R8 no ch0", 32'(ch_sel), 0);
    @(negedge clk); bus_rd = 1'b0;
    rd(32'h36, d); check("R11 ctrl low bits", d, 1);
    wr(32'h34, 0);
    check("R8 cleared", 32'(addr32_en), 0);
  endtask

  task automatic t_undecoded;
    logic [31:0] d;
    @(negedge clk); bus_addr = AW'(32'h100); bus_rd = 1'b1; #1;
    check("R10 past windows", bus_rdata, 0);
    check("R10 no sel", 32'(ch_sel), 0);
    @(negedge clk); bus_rd = 1'b0;
    wr(32'h80010, 32'hFFFF_FFFF);
    wr(32'h8000C, 32'hFFFF_FFFF);
    rd(32'h80008, d); check("R10 enable untouched", d, 0);
    rd(32'h80000, d); check("R10 status untouched", d, 0);
    rd(32'h80010, d); check("R10 read zero", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_set_clear();
    t_set_wins();
    t_enable_pending();
    t_width();
    t_windows();
    t_ctrl();
    t_undecoded();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule